// File: doc/BRIEF.md
# Selectable Clock Output Controller

This block produces a clock for an external microcontroller from the chip's fast reference clock. A 3-bit select code in a control byte picks one of seven divided-down rates or a separate low-frequency clock input. All of the divided rates come from a single half-period counter, including the 7.5 ratio. Every change of source happens only while the output is low. The output therefore never carries a pulse shorter than the pulses of the sources it moves between.

When the host chip asks to sleep, the block can do one of two things. It can hand the output over to the low-frequency clock. Or it can let the current clock run for a programmed number of extra rising edges and then hold the output low. While an interrupt is pending the sleep request is held back, so the output keeps running. Once the request is withdrawn, the selected rate comes back at the first low point of the output. The control byte comes from a register outside this block and is sampled on every reference edge.

Top module: `mcu_clk_out`

## Requirements
- R1: The control byte is decoded as select code in bits 2:0, low-frequency enable in bit 4 and tail length in bits 7:6. Bits 3 and 5 have no effect on the output.
- R2: Select codes 0 to 6 give an output period of 1, 2, 3, 7.5, 10, 15 and 30 reference cycles. In units of reference half-periods, the output is high for the integer half of that period, and each period starts with its high part.
- R3: Select code 7 outputs the low-frequency input after a two-stage reference-clock synchroniser, with the same period and high time.
- R4: A change of source takes effect only at a reference edge where the output is low. A newly selected divided clock starts with a full high part.
- R5: With sleep requested, no interrupt pending and the enable bit at 1, the output is the synchronised low-frequency clock, whatever the select code.
- R6: With sleep requested, no interrupt pending and the enable bit at 0, the output gives exactly 0, 128, 256 or 512 more rising edges for tail codes 0, 1, 2 and 3. It then stays low.
- R7: While the interrupt-pending input is 1, the output behaves as when awake. The tail count starts only once the interrupt clears.
- R8: Withdrawing the sleep request restores the source named by the select code at the first reference edge where the output is low.
- R9: A switch into the low-frequency clock waits until the synchronised low-frequency level is low.
- R10: While rst_n is low at a rising reference edge, the output is low during the following reference cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_lf | input | 1 | Low-frequency clock, asynchronous to clk_ref |
| sleep_req | input | 1 | Host sleep request, synchronous to clk_ref |
| irq_pend | input | 1 | Interrupt pending, holds the clock running |
| ctrl_byte | input | 8 | Control byte: tail, low-frequency enable, select |
| clk_mcu | output | 1 | Clock delivered to the microcontroller |

## Verification
A half-period counter holding the wrong value shows up as a wrong high or low width within one output period. A source register that does not match the request shows as a wrong period, or as a clock that stops or keeps running, within one period of the old source. The tail counter is visible only through the number of edges after a sleep request, so a count that is off by one shows up as a single extra or missing rising edge just before the output stops. Every half of every reference cycle is compared against a behavioural model, so any such deviation is caught at the half-period where it first appears.

// File: rtl/mco_pkg.sv
`timescale 1ns/1ps
// Shared types and rate table for the selectable clock output controller.
// Assumes a reference clock at the highest output rate; ratios are in half-periods.
package mco_pkg;

    localparam int HALF_W = 6;              // holds the longest period in half-periods
    localparam logic [2:0] CODE_LF = 3'd7;  // select code that routes the slow clock

    typedef enum logic [1:0] {
        SRC_DIV = 2'd0,
        SRC_LF  = 2'd1,
        SRC_OFF = 2'd2
    } src_kind_e;

    typedef struct packed {
        src_kind_e  kind;
        logic [2:0] code;   // divider code, zero for the other kinds
    } src_t;

    // Output period in reference half-periods for each divided select code.
    function automatic logic [HALF_W-1:0] half_len(input logic [2:0] code);
        case (code)
            3'd0:    half_len = HALF_W'(2);
            3'd1:    half_len = HALF_W'(4);
            3'd2:    half_len = HALF_W'(6);
            3'd3:    half_len = HALF_W'(15);
            3'd4:    half_len = HALF_W'(20);
            3'd5:    half_len = HALF_W'(30);
            default: half_len = HALF_W'(60);
        endcase
    endfunction

endpackage

// File: rtl/mco_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser bringing the asynchronous slow clock level into the
// reference domain. Assumes the slow clock is far slower than the reference.
module mco_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] shift_q;

    // Shift the sampled level through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[STAGES-2:0], d};
    end

    assign q = shift_q[STAGES-1];
endmodule

// File: rtl/mco_half_div.sv
`timescale 1ns/1ps
// Half-period divider: each reference cycle it yields the output level for the
// low half (ph_a) and for the following high half (ph_b) of the reference clock.
// A period of odd half-period length, such as 15 for the 7.5 ratio, needs no
// second clock edge. Assumes restart is raised on the cycle a new code takes over.
module mco_half_div import mco_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       restart,
    input  logic [2:0] code,
    output logic       ph_a,
    output logic       ph_b
);
    logic [HALF_W-1:0] h_q, h_use, h_one, h_two, dlen, hi_len;

    // Derive the two half levels and the phase two half-periods on.
    always_comb begin
        dlen   = half_len(code);
        hi_len = dlen >> 1;
        h_use  = restart ? '0 : h_q;
        h_one  = h_use + HALF_W'(1);
        if (h_one >= dlen) h_one = h_one - dlen;
        h_two  = h_one + HALF_W'(1);
        if (h_two >= dlen) h_two = h_two - dlen;
        ph_a   = (h_use < hi_len);
        ph_b   = (h_one < hi_len);
    end

    // Advance the phase while a divided source is in use.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) h_q <= '0;
        else                   h_q <= h_two;
    end

    // R2: the phase stays inside the period of the code it was computed for.
    p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !restart) |-> (h_q < dlen));
endmodule

// File: rtl/mco_sleep_ctl.sv
`timescale 1ns/1ps
// Sleep policy: turns the sleep request, interrupt hold and control fields into
// the source the output should move to. Counts rising edges of the issued output
// during the clock tail. Assumes rise marks the cycles whose pair holds a rising edge.
module mco_sleep_ctl import mco_pkg::*; #(
    parameter int TAIL_BASE = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       irq_pend,
    input  logic       lf_en,
    input  logic [1:0] tail,
    input  logic [2:0] sel,
    input  logic       rise,
    output src_t       req
);
    localparam int CNT_W = $clog2(TAIL_BASE * 4 + 1);

    logic             asleep;
    logic [CNT_W-1:0] cnt_q, tail_len;
    src_t             awake_src;

    // Decide the wanted source from the mode and the tail progress.
    always_comb begin
        asleep   = sleep_req && !irq_pend;
        tail_len = (tail == 2'd0) ? '0 : (CNT_W'(TAIL_BASE) << (tail - 2'd1));
        if (sel == CODE_LF) awake_src = '{kind: SRC_LF,  code: 3'd0};
        else                awake_src = '{kind: SRC_DIV, code: sel};
        req = awake_src;
        if (asleep) begin
            if (lf_en)                  req = '{kind: SRC_LF,  code: 3'd0};
            else if (cnt_q >= tail_len) req = '{kind: SRC_OFF, code: 3'd0};
        end
    end

    // Count tail edges from the first sleeping cycle, cleared when awake.
    always_ff @(posedge clk) begin
        if (!rst_n || !asleep)            cnt_q <= '0;
        else if (rise && cnt_q < tail_len) cnt_q <= cnt_q + 1'b1;
    end

    // R6: with a steady tail field the count never passes the programmed length.
    p_tail_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && $past(asleep) && $stable(tail)) |-> (cnt_q <= tail_len));
endmodule

// File: rtl/mco_src_sel.sv
`timescale 1ns/1ps
// Glitch-free source selector and output stage. A new source is taken only after
// a low half, and the slow clock only while its level is low. The low-half level
// is held on the rising edge and the high-half level on the falling edge, so the
// final mux input in use is always stable. Assumes req is synchronous to clk.
module mco_src_sel import mco_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  src_t req,
    input  logic lf_lvl,
    input  logic div_a,
    input  logic div_b,
    output src_t eff,
    output src_t cur,
    output logic sw,
    output logic rise,
    output logic clk_out
);
    src_t src_q;
    logic a_q, b_q, b_hi_q;
    logic nxt_a, nxt_b;

    // Decide whether to switch this cycle and which source then drives.
    always_comb begin
        sw  = (req != src_q) && !b_q && !(req.kind == SRC_LF && lf_lvl);
        eff = sw ? req : src_q;
    end

    // Pick the next half-period pair from the driving source.
    always_comb begin
        case (eff.kind)
            SRC_DIV: begin nxt_a = div_a;  nxt_b = div_b;  end
            SRC_LF:  begin nxt_a = lf_lvl; nxt_b = lf_lvl; end
            default: begin nxt_a = 1'b0;   nxt_b = 1'b0;   end
        endcase
        rise = (!b_q && nxt_a) || (!nxt_a && nxt_b);
    end

    // Register the source and the low-half level on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '{kind: SRC_DIV, code: 3'd6};
            a_q   <= 1'b0;
            b_q   <= 1'b0;
        end else begin
            src_q <= eff;
            a_q   <= nxt_a;
            b_q   <= nxt_b;
        end
    end

    // Move the high-half level across on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) b_hi_q <= 1'b0;
        else        b_hi_q <= b_q;
    end

    assign clk_out = clk ? b_hi_q : a_q;
    assign cur     = src_q;

    // R4: the source register only changes after a low high-half level.
    p_switch_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q != $past(src_q)) |-> !$past(b_q));

    // R9: entry into the slow clock happens only while its level is low.
    p_lf_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q.kind == SRC_LF && $past(src_q.kind) != SRC_LF) |-> !$past(lf_lvl));
endmodule

// File: rtl/mcu_clk_out.sv
`timescale 1ns/1ps
// Top of the selectable clock output controller. It decodes the control byte and
// joins the slow-clock synchroniser, the sleep policy, the half-period divider and
// the glitch-free selector. Assumes sleep_req, irq_pend and ctrl_byte are
// synchronous to clk_ref.
module mcu_clk_out import mco_pkg::*; #(
    parameter int TAIL_BASE   = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_ref,
    input  logic       rst_n,
    input  logic       clk_lf,
    input  logic       sleep_req,
    input  logic       irq_pend,
    input  logic [7:0] ctrl_byte,
    output logic       clk_mcu
);
    logic lf_lvl, sw, rise, div_a, div_b;
    src_t req, eff, cur;
    logic unused_ctrl;

    assign unused_ctrl = ^{ctrl_byte[5], ctrl_byte[3]};

    mco_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .d     (clk_lf),
        .q     (lf_lvl)
    );

    mco_sleep_ctl #(.TAIL_BASE(TAIL_BASE)) u_sleep (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .irq_pend  (irq_pend),
        .lf_en     (ctrl_byte[4]),
        .tail      (ctrl_byte[7:6]),
        .sel       (ctrl_byte[2:0]),
        .rise      (rise),
        .req       (req)
    );

    mco_half_div u_div (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .active  (eff.kind == SRC_DIV),
        .restart (sw),
        .code    (eff.code),
        .ph_a    (div_a),
        .ph_b    (div_b)
    );

    mco_src_sel u_sel (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .req     (req),
        .lf_lvl  (lf_lvl),
        .div_a   (div_a),
        .div_b   (div_b),
        .eff     (eff),
        .cur     (cur),
        .sw      (sw),
        .rise    (rise),
        .clk_out (clk_mcu)
    );

    // R7: a running output is not stopped while an interrupt is pending.
    p_irq_hold_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (irq_pend && cur.kind != SRC_OFF) |=> (cur.kind != SRC_OFF));

    // R5: once on the slow clock in low-frequency sleep, it stays there.
    p_sleep_lf_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (sleep_req && !irq_pend && ctrl_byte[4] && cur.kind == SRC_LF)
        |=> (cur.kind == SRC_LF));
endmodule

// File: tb/mcu_clk_out_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural per-half-period model compared on every reference cycle,
// plus direct period, width and edge-count measurements at the output.
module mcu_clk_out_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lf_clk = 1'b0;
    logic sleep_req = 1'b0;
    logic irq_pend = 1'b0;
    logic [7:0] ctrl = 8'h06;
    logic clk_mcu;

    int checks = 0;
    int errors = 0;
    int rise_cnt = 0;
    int cyc = 0;
    string tag = "R10";
    bit done = 1'b0;

    always #4 clk = ~clk;

    mcu_clk_out dut_i (
        .clk_ref   (clk),
        .rst_n     (rst_n),
        .clk_lf    (lf_clk),
        .sleep_req (sleep_req),
        .irq_pend  (irq_pend),
        .ctrl_byte (ctrl),
        .clk_mcu   (clk_mcu)
    );

    // Slow clock: toggles every 20 reference cycles.
    int lf_div = 0;
    always @(negedge clk) begin
        lf_div++;
        if (lf_div == 20) begin lf_div = 0; lf_clk = ~lf_clk; end
    end

    always @(posedge clk_mcu) rise_cnt++;

    task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d at %0t", rq, what, act, exp, $time);
        end
    endtask

    function automatic int hlen(input int code);
        case (code)
            0: return 2;  1: return 4;  2: return 6;  3: return 15;
            4: return 20; 5: return 30; default: return 60;
        endcase
    endfunction

    // Reference model: kind 0 divided, 1 slow clock, 2 off.
    int m_kind = 0, m_code = 6, m_ph = 0, m_prevb = 0, m_cnt = 0;
    int m_s1 = 0, m_s2 = 0, ea = 0, eb = 0, eb_prev = 0;
    always @(posedge clk) begin
        int rk, rc, len, lfs, d, na, nb;
        bit slp, sw;
        eb_prev = eb;
        if (!rst_n) begin
            m_kind = 0; m_code = 6; m_ph = 0; m_prevb = 0; m_cnt = 0;
            m_s1 = 0; m_s2 = 0; ea = 0; eb = 0;
        end else begin
            lfs = m_s2;
            slp = sleep_req && !irq_pend;
            len = (ctrl[7:6] == 0) ? 0 : (64 << ctrl[7:6]);
            rk = (ctrl[2:0] == 7) ? 1 : 0;
            rc = (ctrl[2:0] == 7) ? 0 : int'(ctrl[2:0]);
            if (slp && ctrl[4]) begin rk = 1; rc = 0; end
            else if (slp && m_cnt >= len) begin rk = 2; rc = 0; end
            sw = (rk != m_kind || rc != m_code) && m_prevb == 0 && !(rk == 1 && lfs == 1);
            if (sw) begin m_kind = rk; m_code = rc; m_ph = 0; end
            if (m_kind == 0) begin
                d = hlen(m_code);
                na = (m_ph < d / 2) ? 1 : 0;
                nb = (((m_ph + 1) % d) < d / 2) ? 1 : 0;
                m_ph = (m_ph + 2) % d;
            end else if (m_kind == 1) begin
                na = lfs; nb = lfs;
            end else begin
                na = 0; nb = 0;
            end
            if (!slp) m_cnt = 0;
            else if (((m_prevb == 0 && na == 1) || (na == 0 && nb == 1)) && m_cnt < len) m_cnt++;
            m_prevb = nb; ea = na; eb = nb;
            m_s2 = m_s1; m_s1 = int'(lf_clk);
        end
        cyc++;
        if (cyc > 2) begin
            #2 check(int'(clk_mcu) == eb_prev, tag, "model high-half level", int'(clk_mcu), eb_prev);
            #4 check(int'(clk_mcu) == ea, tag, "model low-half level", int'(clk_mcu), ea);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input int per_ns, input int hi_ns, input string rq);
        realtime t0, t1, t2;
        @(posedge clk_mcu); t0 = $realtime;
        @(negedge clk_mcu); t1 = $realtime;
        @(posedge clk_mcu); t2 = $realtime;
        check(int'(t2 - t0) == per_ns, rq, "period ns", int'(t2 - t0), per_ns);
        check(int'(t1 - t0) == hi_ns, rq, "high time ns", int'(t1 - t0), hi_ns);
    endtask

    task automatic clear_rises;
        @(posedge clk); #1 rise_cnt = 0;
    endtask

    initial begin
        // R10: output low while reset is held.
        wait_cyc(3);
        @(posedge clk); #2 check(clk_mcu == 1'b0, "R10", "reset high half", int'(clk_mcu), 0);
        @(negedge clk); #2 check(clk_mcu == 1'b0, "R10", "reset low half", int'(clk_mcu), 0);
        wait_cyc(2);
        rst_n = 1'b1;

        // R2 and R1: every divided rate, with unused bits 5/3 and the tail field set.
        for (int c = 0; c < 7; c++) begin
            wait_cyc(1);
            tag = "R2";
            ctrl = 8'(c) | ((c % 2 == 0) ? 8'h28 : 8'h00) | 8'h40;
            wait_cyc(200);
            measure(hlen(c) * 4, (hlen(c) / 2) * 4, (c % 2 == 0) ? "R1" : "R2");
        end

        // R3: slow clock routed by select code 7.
        wait_cyc(1); tag = "R3"; ctrl = 8'h07;
        wait_cyc(200);
        measure(320, 160, "R3");

        // R5 then R8: slow clock in sleep, then back to the fastest rate.
        wait_cyc(1); tag = "R4"; ctrl = 8'h00;
        wait_cyc(50);
        tag = "R5"; ctrl = 8'h10; sleep_req = 1'b1;
        wait_cyc(200);
        measure(320, 160, "R5");
        wait_cyc(1); tag = "R8"; sleep_req = 1'b0;
        wait_cyc(100);
        measure(8, 4, "R8");

        // R6: each tail length at the fastest rate.
        for (int t = 0; t < 4; t++) begin
            int exp_n;
            exp_n = (t == 0) ? 0 : (64 << t);
            wait_cyc(1); tag = "R6"; ctrl = 8'(t << 6); sleep_req = 1'b0;
            wait_cyc(50);
            sleep_req = 1'b1;
            clear_rises();
            wait_cyc(700);
            check(rise_cnt == exp_n, "R6", "tail rising edges", rise_cnt, exp_n);
            wait_cyc(1); tag = "R8"; sleep_req = 1'b0;
            wait_cyc(30);
            measure(8, 4, "R8");
        end

        // R6: tail at the slowest divided rate.
        wait_cyc(1); tag = "R6"; ctrl = 8'h46;
        wait_cyc(200);
        sleep_req = 1'b1;
        clear_rises();
        wait_cyc(4500);
        check(rise_cnt == 128, "R6", "tail edges at slow rate", rise_cnt, 128);
        wait_cyc(1); sleep_req = 1'b0; tag = "R8";
        wait_cyc(200);

        // R7: a pending interrupt keeps the clock and delays the tail.
        wait_cyc(1); tag = "R7"; ctrl = 8'h40;
        wait_cyc(50);
        irq_pend = 1'b1; sleep_req = 1'b1;
        clear_rises();
        wait_cyc(300);
        check(rise_cnt >= 290, "R7", "edges during interrupt hold", rise_cnt, 290);
        irq_pend = 1'b0;
        clear_rises();
        wait_cyc(400);
        check(rise_cnt == 128, "R7", "tail after interrupt clears", rise_cnt, 128);
        wait_cyc(1); sleep_req = 1'b0;

        // R9: enter slow-clock sleep while the slow clock is high.
        wait_cyc(50);
        tag = "R9"; ctrl = 8'h10;
        wait (lf_clk == 1'b1);
        wait_cyc(3);
        sleep_req = 1'b1;
        wait_cyc(200);
        measure(320, 160, "R9");
        wait_cyc(1); sleep_req = 1'b0;
        wait_cyc(100);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog run did not complete actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule